// File: doc/BRIEF.md
# Big-Endian Load/Store Alignment Unit

This block sits between a processor's load/store stage and a 64-bit data memory. Each access comes in as a 32-bit byte address, a size code, a signed/unsigned flag, the register number it reads from or writes to, and the store data. In the same cycle the block produces the memory strobe, the aligned double-word address, the per-byte enables and the store data placed into the right byte lanes. The memory is assumed to answer a read in the following cycle.

The memory is big-endian. The byte at the lowest address is the most significant byte of any multi-byte value. Load data coming back from memory is moved down to the low end of a register word and extended according to the signed flag. A double-word load fills two registers. An access whose address is not a multiple of its size is refused with an alignment trap, and so is a double-word access that names an odd first register. A refused access never reaches memory.

Top module: `lsa_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it with no request, `ldValid`, `trapValid` and `memEn` are low and `trapType` is 0.
- R2: Size codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. A request whose address is not a multiple of its byte count raises `trapValid` in the same cycle, with `trapType` = 7. In that cycle `memEn` is low and `memBe` is all zero.
- R3: A size-3 request whose `reqReg` is odd raises the same trap, with `trapType` = 7 and no memory access.
- R4: A request that does not trap drives `memEn` high in the same cycle, with `memWe` equal to `reqStore` and `memAddr` equal to `reqAddr` with bits 2:0 cleared. When there is no such request, `memEn` is low and `memBe` is zero.
- R5: Let k = `reqAddr[2:0]`. The byte at address offset k+i uses lane k+i. Lane j is enabled by `memBe[7-j]`, and exactly as many enables are set as the access has bytes.
- R6: Lane j of the 64-bit data bus is `memWdata[63-8j -: 8]`. Store data is taken right-justified from `stData[31:0]` for sizes 0 to 2, and from all of `stData` for size 3. Its most significant byte goes to the lowest address. Lanes that are not enabled carry zero.
- R7: One cycle after an accepted load, `ldValid` is high and `ldReg` equals the request's register number. For sizes 0 to 2, the loaded bytes appear right-justified in `ldWord0`, with the lowest-address byte most significant.
- R8: Byte and half-word loads are sign-extended to 32 bits when `reqSigned` was 1, and zero-extended when it was 0. Word loads are returned unchanged.
- R9: For a size-3 load, `ldPair` is 1. `ldWord0`, meant for the even register, holds the word at the lower address. `ldWord1`, meant for the odd register, holds the word at the higher address. For any other load, `ldPair` is 0 and `ldWord1` is 0.
- R10: A store or a trapped request is never followed by `ldValid` in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqStore | input | 1 | 1 = store, 0 = load |
| reqSize | input | 2 | 0 byte, 1 half-word, 2 word, 3 double-word |
| reqSigned | input | 1 | Sign-extend byte and half-word loads |
| reqAddr | input | 32 | Byte address |
| reqReg | input | 5 | Source or destination register number |
| stData | input | 64 | Store data, right-justified |
| memEn | output | 1 | Memory access strobe |
| memWe | output | 1 | Memory write enable |
| memAddr | output | 32 | Double-word aligned address |
| memBe | output | 8 | Byte enables; bit 7 is the lane at the lowest address |
| memWdata | output | 64 | Lane-aligned write data |
| memRdata | input | 64 | Read data, valid one cycle after a load strobe |
| trapValid | output | 1 | Alignment trap raised |
| trapType | output | 8 | Trap code, 7 when trapping, else 0 |
| ldValid | output | 1 | Load result present |
| ldReg | output | 5 | Destination register of the result |
| ldPair | output | 1 | Result fills a register pair |
| ldWord0 | output | 32 | Result for `ldReg` |
| ldWord1 | output | 32 | Result for `ldReg`+1 in a pair |

## Verification
The bench builds the unit with its default parameters: 32-bit addresses, 5-bit register numbers and trap code 7. The memory attached to it covers only a 64-byte window, and the upper address bits still vary freely. With this window, every byte offset in the double-word, every size, both extension modes and both register parities occur many times. Stores are later read back through loads of other sizes. This shows that byte ordering is consistent between the write path and the read path.

// File: rtl/lsa_pkg.sv
package lsa_pkg;
  localparam int BUS_BYTES = 8;
  localparam int LANE_W    = $clog2(BUS_BYTES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } accSize_e;

  // strobes for the request-side datapath (same cycle)
  typedef struct packed {
    logic              accept;
    logic              store;
    accSize_e          size;
    logic [LANE_W-1:0] offset;
  } reqStrobe_t;

  // strobes for the response-side datapath (one cycle later)
  typedef struct packed {
    logic              valid;
    logic              sExt;
    accSize_e          size;
    logic [LANE_W-1:0] offset;
  } rspStrobe_t;
endpackage

// File: rtl/lsa_ctrl.sv
module lsa_ctrl
  import lsa_pkg::*;
#(
  parameter int REG_W     = 5,
  parameter int TRAP_W    = 8,
  parameter int TRAP_CODE = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [LANE_W-1:0] reqOffset,
  input  logic [REG_W-1:0]  reqReg,
  output reqStrobe_t        reqStb,
  output rspStrobe_t        rspStb,
  output logic              memEn,
  output logic              memWe,
  output logic              trapValid,
  output logic [TRAP_W-1:0] trapType,
  output logic              ldValid,
  output logic [REG_W-1:0]  ldReg,
  output logic              ldPair
);
  accSize_e   sizeCode;
  logic       misAlign;
  logic       oddPair;
  logic       accept;
  rspStrobe_t rspQ;
  logic [REG_W-1:0] regQ;

  assign sizeCode = accSize_e'(reqSize);

  always_comb begin
    unique case (sizeCode)
      SZ_BYTE:  misAlign = 1'b0;
      SZ_HALF:  misAlign = reqOffset[0];
      SZ_WORD:  misAlign = |reqOffset[1:0];
      default:  misAlign = |reqOffset;
    endcase
  end

  assign oddPair   = (sizeCode == SZ_DWORD) && reqReg[0];
  assign trapValid = reqValid && (misAlign || oddPair);
  assign trapType  = trapValid ? TRAP_W'(TRAP_CODE) : '0;
  assign accept    = reqValid && !trapValid;
  assign memEn     = accept;
  assign memWe     = accept && reqStore;

  assign reqStb.accept = accept;
  assign reqStb.store  = reqStore;
  assign reqStb.size   = sizeCode;
  assign reqStb.offset = reqOffset;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspQ <= '0;
      regQ <= '0;
    end else begin
      rspQ.valid <= accept && !reqStore;
      if (accept && !reqStore) begin
        rspQ.sExt   <= reqSigned;
        rspQ.size   <= sizeCode;
        rspQ.offset <= reqOffset;
        regQ        <= reqReg;
      end
    end
  end

  assign rspStb  = rspQ;
  assign ldValid = rspQ.valid;
  assign ldReg   = regQ;
  assign ldPair  = rspQ.valid && (rspQ.size == SZ_DWORD);

  // R2 / R3: a trapped request never reaches memory
  a_r2_trap_blocks_access: assert property (@(posedge clk) disable iff (!rstN)
    trapValid |-> !memEn && !memWe && trapType == TRAP_W'(TRAP_CODE));

  // R3: odd first register of a pair
  a_r3_odd_pair_traps: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqSize == 2'd3 && reqReg[0]) |-> trapValid);

  // R7: a load result only follows an accepted load
  a_r7_result_follows_load: assert property (@(posedge clk) disable iff (!rstN)
    ldValid |-> $past(memEn && !memWe));

  // R10: stores and traps produce no result
  a_r10_no_result_after_store: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || trapValid) |=> !ldValid);
endmodule

// File: rtl/lsa_datapath.sv
module lsa_datapath
  import lsa_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  reqStrobe_t             reqStb,
  input  rspStrobe_t             rspStb,
  input  logic [8*BUS_BYTES-1:0] stData,
  input  logic [8*BUS_BYTES-1:0] memRdata,
  output logic [BUS_BYTES-1:0]   memBe,
  output logic [8*BUS_BYTES-1:0] memWdata,
  output logic [31:0]            ldWord0,
  output logic [31:0]            ldWord1
);
  localparam int CNT_W  = LANE_W + 1;
  localparam int BITS   = 8 * BUS_BYTES;
  localparam int SHF_W  = CNT_W + 3;

  logic [CNT_W-1:0] reqBytes;
  logic [CNT_W-1:0] reqEnd;
  logic [CNT_W-1:0] reqPad;
  logic [BITS-1:0]  srcMasked;
  logic [CNT_W-1:0] rspBytes;
  logic [CNT_W-1:0] rspPad;
  logic [BITS-1:0]  rdShifted;

  // ---------------- store side ----------------
  assign reqBytes = CNT_W'(1) << reqStb.size;
  assign reqEnd   = {1'b0, reqStb.offset} + reqBytes;
  assign reqPad   = CNT_W'(BUS_BYTES) - reqEnd;

  genvar k;
  generate
    for (k = 0; k < BUS_BYTES; k++) begin : g_lane
      assign memBe[BUS_BYTES-1-k] = reqStb.accept
                                    && (CNT_W'(k) >= {1'b0, reqStb.offset})
                                    && (CNT_W'(k) < reqEnd);
    end
  endgenerate

  always_comb begin
    unique case (reqStb.size)
      SZ_BYTE:  srcMasked = {{(BITS-8){1'b0}},  stData[7:0]};
      SZ_HALF:  srcMasked = {{(BITS-16){1'b0}}, stData[15:0]};
      SZ_WORD:  srcMasked = {{(BITS-32){1'b0}}, stData[31:0]};
      default:  srcMasked = stData;
    endcase
  end

  assign memWdata = (reqStb.accept && reqStb.store)
                    ? (srcMasked << {reqPad, 3'b000}) : '0;

  // ---------------- load side ----------------
  assign rspBytes  = CNT_W'(1) << rspStb.size;
  assign rspPad    = CNT_W'(BUS_BYTES) - ({1'b0, rspStb.offset} + rspBytes);
  assign rdShifted = memRdata >> SHF_W'({rspPad, 3'b000});

  always_comb begin
    ldWord0 = '0;
    ldWord1 = '0;
    if (rspStb.valid) begin
      unique case (rspStb.size)
        SZ_BYTE:  ldWord0 = {{24{rspStb.sExt && rdShifted[7]}},  rdShifted[7:0]};
        SZ_HALF:  ldWord0 = {{16{rspStb.sExt && rdShifted[15]}}, rdShifted[15:0]};
        SZ_WORD:  ldWord0 = rdShifted[31:0];
        default: begin
          ldWord0 = memRdata[BITS-1:BITS-32];
          ldWord1 = memRdata[31:0];
        end
      endcase
    end
  end

  // R5: enable count matches the access size
  a_r5_enable_count: assert property (@(posedge clk) disable iff (!rstN)
    reqStb.accept |-> $countones(memBe) == int'(reqBytes));

  // R4: no enables without an accepted access
  a_r4_idle_no_enables: assert property (@(posedge clk) disable iff (!rstN)
    !reqStb.accept |-> memBe == '0);

  // R6: write data only on enabled lanes
  a_r6_quiet_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (reqStb.accept && reqStb.store && reqStb.size == SZ_BYTE) |->
      $countones(memWdata & ~{{8{memBe[7]}}, {8{memBe[6]}}, {8{memBe[5]}}, {8{memBe[4]}},
                              {8{memBe[3]}}, {8{memBe[2]}}, {8{memBe[1]}}, {8{memBe[0]}}}) == 0);

  // R9: upper result word is idle outside pairs
  a_r9_single_hi_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rspStb.valid && rspStb.size != SZ_DWORD) |-> ldWord1 == '0);
endmodule

// File: rtl/lsa_unit.sv
module lsa_unit
  import lsa_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int REG_W     = 5,
  parameter int TRAP_W    = 8,
  parameter int TRAP_CODE = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqStore,
  input  logic [1:0]        reqSize,
  input  logic              reqSigned,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [63:0]       stData,
  output logic              memEn,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memBe,
  output logic [63:0]       memWdata,
  input  logic [63:0]       memRdata,
  output logic              trapValid,
  output logic [TRAP_W-1:0] trapType,
  output logic              ldValid,
  output logic [REG_W-1:0]  ldReg,
  output logic              ldPair,
  output logic [31:0]       ldWord0,
  output logic [31:0]       ldWord1
);
  reqStrobe_t reqStb;
  rspStrobe_t rspStb;

  assign memAddr = {reqAddr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};

  lsa_ctrl #(
    .REG_W     (REG_W),
    .TRAP_W    (TRAP_W),
    .TRAP_CODE (TRAP_CODE)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqStore  (reqStore),
    .reqSize   (reqSize),
    .reqSigned (reqSigned),
    .reqOffset (reqAddr[LANE_W-1:0]),
    .reqReg    (reqReg),
    .reqStb    (reqStb),
    .rspStb    (rspStb),
    .memEn     (memEn),
    .memWe     (memWe),
    .trapValid (trapValid),
    .trapType  (trapType),
    .ldValid   (ldValid),
    .ldReg     (ldReg),
    .ldPair    (ldPair)
  );

  lsa_datapath u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .reqStb   (reqStb),
    .rspStb   (rspStb),
    .stData   (stData),
    .memRdata (memRdata),
    .memBe    (memBe),
    .memWdata (memWdata),
    .ldWord0  (ldWord0),
    .ldWord1  (ldWord1)
  );
endmodule

// File: tb/lsa_unit_tb.sv
module lsa_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqStore = 1'b0, reqSigned = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqAddr = '0;
  logic [4:0]  reqReg = '0;
  logic [63:0] stData = '0;
  logic        memEn, memWe, trapValid, ldValid, ldPair;
  logic [31:0] memAddr, ldWord0, ldWord1;
  logic [7:0]  memBe, trapType;
  logic [63:0] memWdata;
  logic [63:0] memRdata = '0;
  logic [4:0]  ldReg;

  int nVec = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  lsa_unit u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqStore(reqStore),
    .reqSize(reqSize), .reqSigned(reqSigned), .reqAddr(reqAddr), .reqReg(reqReg),
    .stData(stData), .memEn(memEn), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata),
    .trapValid(trapValid), .trapType(trapType), .ldValid(ldValid),
    .ldReg(ldReg), .ldPair(ldPair), .ldWord0(ldWord0), .ldWord1(ldWord1)
  );

  // bus-side memory (64-byte window, lane j = bits 63-8j)
  logic [7:0] busMem [64];
  // reference memory, byte addressed
  logic [7:0] refMem [64];

  initial begin
    for (int i = 0; i < 64; i++) begin
      busMem[i] = 8'(i * 37 + 133);
      refMem[i] = 8'(i * 37 + 133);
    end
  end

  always @(posedge clk) begin
    if (memEn) begin
      for (int j = 0; j < 8; j++) begin
        if (memWe && memBe[7-j])
          busMem[{memAddr[5:3], 3'(j)}] <= memWdata[8*(7-j) +: 8];
      end
      if (!memWe)
        for (int j = 0; j < 8; j++)
          memRdata[8*(7-j) +: 8] <= busMem[{memAddr[5:3], 3'(j)}];
    end
  end

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // pending expected load result
  bit          pValid = 0, pPair = 0;
  logic [4:0]  pReg = '0;
  logic [31:0] pW0 = '0, pW1 = '0;

  always @(negedge clk) begin
    if (!rstN) begin
      check("R1 ldValid in reset", 64'(ldValid), 64'd0);
      pValid = 0;
    end else begin
      int n, off;
      bit mis, odd, trapE, accE;
      logic [7:0] beE;
      logic [63:0] wdE, val;
      // ---- result of the previous cycle's load (R7/R8/R9/R10)
      check(pValid ? "R7 ldValid" : "R10 ldValid", 64'(ldValid), 64'(pValid));
      if (pValid) begin
        check("R7 ldReg", 64'(ldReg), 64'(pReg));
        check("R8 ldWord0", 64'(ldWord0), 64'(pW0));
        check("R9 ldWord1", 64'(ldWord1), 64'(pW1));
        check("R9 ldPair", 64'(ldPair), 64'(pPair));
      end
      // ---- current request
      n    = 1 << reqSize;
      off  = int'(reqAddr[2:0]);
      mis  = (int'(reqAddr[2:0]) % n) != 0;
      odd  = (n == 8) && reqReg[0];
      trapE = reqValid && (mis || odd);
      accE  = reqValid && !trapE;
      check(odd && !mis ? "R3 trapValid" : "R2 trapValid", 64'(trapValid), 64'(trapE));
      check("R2 trapType", 64'(trapType), trapE ? 64'd7 : 64'd0);
      check("R4 memEn", 64'(memEn), 64'(accE));
      beE = '0; wdE = '0;
      if (accE) begin
        check("R4 memWe", 64'(memWe), 64'(reqStore));
        check("R4 memAddr", 64'(memAddr), 64'(reqAddr & 32'hFFFF_FFF8));
        for (int i = 0; i < n; i++) begin
          beE[7-(off+i)] = 1'b1;
          wdE[8*(7-off-i) +: 8] = stData[8*(n-1-i) +: 8];
        end
      end
      check("R5 memBe", 64'(memBe), 64'(beE));
      if (accE && reqStore) begin
        check("R6 memWdata", memWdata, wdE);
        for (int i = 0; i < n; i++)
          refMem[(int'(reqAddr[5:0]) + i) % 64] = stData[8*(n-1-i) +: 8];
      end
      pValid = accE && !reqStore;
      if (pValid) begin
        val = '0;
        for (int i = 0; i < n; i++)
          val = (val << 8) | 64'(refMem[(int'(reqAddr[5:0]) + i) % 64]);
        pReg = reqReg;
        pPair = (n == 8);
        if (n == 8) begin
          pW0 = val[63:32]; pW1 = val[31:0];
        end else begin
          pW1 = '0;
          if (n == 1)      pW0 = reqSigned ? {{24{val[7]}}, val[7:0]}   : {24'd0, val[7:0]};
          else if (n == 2) pW0 = reqSigned ? {{16{val[15]}}, val[15:0]} : {16'd0, val[15:0]};
          else             pW0 = val[31:0];
        end
      end
    end
  end

  task automatic issue(input bit v, input bit st, input int sz, input bit sg,
                       input logic [31:0] a, input logic [4:0] r, input logic [63:0] d);
    reqValid = v; reqStore = st; reqSize = 2'(sz); reqSigned = sg;
    reqAddr = a; reqReg = r; stData = d;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 trapValid in reset", 64'(trapValid), 64'd0);
    check("R1 memEn in reset", 64'(memEn), 64'd0);
    rstN = 1'b1;
    issue(0, 0, 0, 0, 0, 0, 0);                                  // R1 idle
    issue(1, 1, 0, 0, 32'h1000_0003, 1, 64'hA5);                 // R5 byte store
    issue(1, 1, 1, 0, 32'h1000_0006, 2, 64'hBEEF);               // R6 half store
    issue(1, 1, 2, 0, 32'h2000_0008, 3, 64'h1122_3344);          // R6 word store
    issue(1, 1, 3, 0, 32'h0000_0010, 4, 64'h0102_0304_F5F6_F7F8); // R6 pair store
    issue(1, 0, 0, 1, 32'h1000_0003, 7, 0);                      // R8 signed byte
    issue(1, 0, 0, 0, 32'h1000_0003, 8, 0);                      // R8 unsigned byte
    issue(1, 0, 1, 1, 32'h1000_0006, 9, 0);                      // R8 signed half
    issue(1, 0, 2, 1, 32'h0000_0008, 10, 0);                     // R7 word
    issue(1, 0, 3, 0, 32'h0000_0010, 4, 0);                      // R9 pair
    issue(1, 0, 0, 1, 32'h0000_0014, 11, 0);                     // R8 byte of pair
    issue(1, 0, 1, 0, 32'h0000_0005, 12, 0);                     // R2 half misaligned
    issue(1, 1, 2, 0, 32'h0000_000A, 13, 64'hDEAD);              // R2 word misaligned
    issue(1, 0, 3, 0, 32'h0000_0014, 14, 0);                     // R2 pair misaligned
    issue(1, 1, 3, 0, 32'h0000_0018, 5, 64'hFFFF);               // R3 odd pair
    issue(1, 0, 3, 0, 32'h0000_0018, 5, 0);                      // R3 odd pair load
    issue(1, 0, 2, 0, 32'h0000_0018, 6, 0);                      // R10 load then store
    issue(1, 1, 2, 0, 32'h0000_0018, 6, 64'h5555_AAAA);
    issue(1, 0, 2, 0, 32'h0000_0018, 6, 0);
    for (int t = 0; t < 4000; t++) begin
      int sz;
      logic [31:0] a;
      sz = int'($urandom_range(0, 3));
      a  = $urandom;
      if ($urandom_range(0, 3) != 0) a = a & ~((32'd1 << sz) - 1);
      issue($urandom_range(0, 4) != 0, $urandom_range(0, 1) == 1, sz,
            $urandom_range(0, 1) == 1, a, 5'($urandom),
            {$urandom, $urandom});
    end
    issue(0, 0, 0, 0, 0, 0, 0);
    issue(0, 0, 0, 0, 0, 0, 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule